// File: doc/BRIEF.md
# Segment Limit and Rights Checker

This block checks a single memory access against the segment it goes through while the core runs in protected mode outside the 64-bit mode. It looks at the selector, the segment's access attributes and its limit, and raises a general-protection fault flag when the access is not allowed. The fault always carries error code zero. The block also produces the effective address. That address is cut down to 32 bits when the current address size requires it. The block is purely combinational from the request to its two results. A pipeline stage that owns descriptor loading, paging and fault delivery presents the request and reads back the verdict in the same cycle.

The offset check uses an address width that is chosen for each access. The width exponent comes from an alternate value when the override flag is set and from a default value otherwise. Expand-down segments invert the sense of the limit test. When protection is disabled (real mode), the address passes through untouched and nothing is checked. In 64-bit mode the rights and limit checks are skipped, and only the 32-bit truncation rule still applies.

Top module: `seg_guard`

## Requirements
- R1: While `req_valid` is low, `gp_fault` is low.
- R2: While `prot_en` is low, `gp_fault` is low and `eff_addr` equals `vaddr`.
- R3: With `req_valid`, `prot_en` and not `long_mode`, a selector of zero faults. Segment indices 6 (helper A), 7 (helper B), 8 (task) and 9 (descriptor table) are exempt from this check.
- R4: Segment indices 0 to 6 are the ordinary segments. For them, a write (`acc_kind`=1) or a store probe (`acc_kind`=2) to a segment with `attr_wr` low faults.
- R5: For ordinary segments, a read (`acc_kind`=0) or a store probe with `attr_rd` low faults. A fetch (`acc_kind`=3) never raises a rights fault, and indices 7 to 15 never raise one.
- R6: The width exponent is `alt_asz` when `asz_ovr` is high and `def_asz` otherwise. The width is 8 shifted left by the exponent. The offset is `vaddr` minus `seg_base`, modulo 2 to the power of the width.
- R7: For a segment that is not expand-down, the access faults if the offset exceeds `seg_limit` or if the end offset exceeds it. The end offset is the offset plus `acc_size` minus one, computed one bit wider so that it cannot wrap.
- R8: For an ordinary segment with `attr_xdn` high, the access faults if the offset or the end offset is less than or equal to `seg_limit`.
- R9: When `prot_en` is high and either `sub64` is low or `asz_ovr` is high, `eff_addr` is `vaddr` with bits 63..32 cleared. Otherwise `eff_addr` equals `vaddr`.
- R10: When `prot_en` and `long_mode` are both high, `gp_fault` is low whatever the selector, attributes and limit are.
- R11: Both outputs depend only on the current inputs. They are valid in the same cycle as `req_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used only by the checking properties |
| rst_n | input | 1 | Active-low asynchronous reset, disables the properties |
| req_valid | input | 1 | Access request present |
| prot_en | input | 1 | Protection enabled (low = real mode) |
| long_mode | input | 1 | Core is in 64-bit mode; bypasses the segment checks |
| sub64 | input | 1 | 64-bit submode active (no default truncation) |
| seg_idx | input | 4 | Segment index (0-6 ordinary, 6-9 null-exempt) |
| seg_sel | input | 16 | Segment selector value |
| seg_base | input | 64 | Segment base address |
| seg_limit | input | 32 | Segment limit |
| attr_rd | input | 1 | Segment readable |
| attr_wr | input | 1 | Segment writable |
| attr_xdn | input | 1 | Segment expands down |
| acc_kind | input | 2 | 0 read, 1 write, 2 store probe, 3 fetch |
| acc_size | input | 4 | Access size in bytes (1 or more) |
| def_asz | input | 2 | Default address-size exponent |
| alt_asz | input | 2 | Alternate address-size exponent |
| asz_ovr | input | 1 | Address-size override |
| vaddr | input | 64 | Linear address of the access |
| gp_fault | output | 1 | General-protection fault, error code zero |
| eff_addr | output | 64 | Effective address after truncation |

## Verification
The properties are evaluated on every clock. They cover the quiet output when no request is present, the real-mode pass-through, the long-mode bypass, the clearing of the upper address bits, the faults on a null selector and the write-to-read-only fault. The arithmetic parts can only be shown by the bench's scenarios, which include a reference model. These are the width selected through the override, the offset wrap in a 16-bit width, the limit boundaries where the end offset lands exactly on the limit or one byte past it, and the inverted test for expand-down segments.

// File: rtl/segchk_pkg.sv
package segchk_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_PROBE = 2'd2,
    ACC_FETCH = 2'd3
  } acc_kind_e;

  // Segment indices that take part in the ordering of checks.
  localparam int unsigned SEG_ORD_LAST = 6;
  localparam int unsigned SEG_HELPER_A = 6;
  localparam int unsigned SEG_HELPER_B = 7;
  localparam int unsigned SEG_TASK     = 8;
  localparam int unsigned SEG_DTAB     = 9;
endpackage

// File: rtl/seg_rights_chk.sv
module seg_rights_chk
  import segchk_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int SEL_W = 16
) (
  input  logic [IDX_W-1:0] seg_idx,
  input  logic [SEL_W-1:0] seg_sel,
  input  logic             attr_rd,
  input  logic             attr_wr,
  input  logic             attr_xdn,
  input  acc_kind_e        kind,
  output logic             null_flt,
  output logic             rights_flt,
  output logic             xdn_eff
);
  logic ordinary;
  logic exempt;
  logic wants_wr;
  logic wants_rd;

  always_comb begin
    ordinary = (32'(seg_idx) <= SEG_ORD_LAST);
    exempt   = (32'(seg_idx) == SEG_HELPER_A) || (32'(seg_idx) == SEG_HELPER_B) ||
               (32'(seg_idx) == SEG_TASK)     || (32'(seg_idx) == SEG_DTAB);
    wants_wr = (kind == ACC_WRITE) || (kind == ACC_PROBE);
    wants_rd = (kind == ACC_READ)  || (kind == ACC_PROBE);
    null_flt   = !exempt && (seg_sel == '0);
    rights_flt = ordinary && ((wants_wr && !attr_wr) || (wants_rd && !attr_rd));
    xdn_eff    = ordinary && attr_xdn;
  end
endmodule

// File: rtl/seg_limit_chk.sv
module seg_limit_chk #(
  parameter int VA_W  = 64,
  parameter int LIM_W = 32,
  parameter int SZ_W  = 4
) (
  input  logic [VA_W-1:0]  vaddr,
  input  logic [VA_W-1:0]  base,
  input  logic [LIM_W-1:0] limit,
  input  logic [SZ_W-1:0]  size,
  input  logic [1:0]       wexp,
  input  logic             xdn,
  output logic             lim_flt
);
  localparam int EXT_W = VA_W + 1;
  localparam int NWID  = 4;

  // One mask per selectable width: 8, 16, 32 and 64 bits.
  logic [VA_W-1:0] wmask [NWID];
  for (genvar g = 0; g < NWID; g++) begin : g_wid
    for (genvar b = 0; b < VA_W; b++) begin : g_bit
      assign wmask[g][b] = (b < (8 << g)) ? 1'b1 : 1'b0;
    end
  end

  logic [VA_W-1:0]  diff;
  logic [VA_W-1:0]  offset;
  logic [EXT_W-1:0] off_x;
  logic [EXT_W-1:0] end_x;
  logic [EXT_W-1:0] lim_x;
  logic             below_off;
  logic             below_end;

  always_comb begin
    diff      = vaddr - base;
    offset    = diff & wmask[wexp];
    off_x     = {1'b0, offset};
    end_x     = off_x + EXT_W'(size) - EXT_W'(1);
    lim_x     = EXT_W'(limit);
    below_off = (off_x <= lim_x);
    below_end = (end_x <= lim_x);
    if (xdn) lim_flt = below_off || below_end;
    else     lim_flt = !below_off || !below_end;
  end
endmodule

// File: rtl/seg_addr_mask.sv
module seg_addr_mask #(
  parameter int VA_W = 64
) (
  input  logic [VA_W-1:0] vaddr,
  input  logic            prot_en,
  input  logic            sub64,
  input  logic            asz_ovr,
  output logic [VA_W-1:0] eff_addr
);
  logic narrow;
  assign narrow = prot_en && (!sub64 || asz_ovr);

  if (VA_W > 32) begin : g_wide
    assign eff_addr = narrow ? {{(VA_W-32){1'b0}}, vaddr[31:0]} : vaddr;
  end else begin : g_thin
    assign eff_addr = vaddr;
    logic unused_narrow;
    assign unused_narrow = narrow;
  end
endmodule

// File: rtl/seg_guard.sv
module seg_guard
  import segchk_pkg::*;
#(
  parameter int VA_W  = 64,
  parameter int LIM_W = 32,
  parameter int SEL_W = 16,
  parameter int IDX_W = 4,
  parameter int SZ_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             prot_en,
  input  logic             long_mode,
  input  logic             sub64,
  input  logic [IDX_W-1:0] seg_idx,
  input  logic [SEL_W-1:0] seg_sel,
  input  logic [VA_W-1:0]  seg_base,
  input  logic [LIM_W-1:0] seg_limit,
  input  logic             attr_rd,
  input  logic             attr_wr,
  input  logic             attr_xdn,
  input  logic [1:0]       acc_kind,
  input  logic [SZ_W-1:0]  acc_size,
  input  logic [1:0]       def_asz,
  input  logic [1:0]       alt_asz,
  input  logic             asz_ovr,
  input  logic [VA_W-1:0]  vaddr,
  output logic             gp_fault,
  output logic [VA_W-1:0]  eff_addr
);
  acc_kind_e kind;
  logic      null_flt;
  logic      rights_flt;
  logic      xdn_eff;
  logic      lim_flt;
  logic [1:0] wexp;
  logic      legacy_chk;

  assign kind       = acc_kind_e'(acc_kind);
  assign wexp       = asz_ovr ? alt_asz : def_asz;
  assign legacy_chk = req_valid && prot_en && !long_mode;

  seg_rights_chk #(.IDX_W(IDX_W), .SEL_W(SEL_W)) u_rights (
    .seg_idx   (seg_idx),
    .seg_sel   (seg_sel),
    .attr_rd   (attr_rd),
    .attr_wr   (attr_wr),
    .attr_xdn  (attr_xdn),
    .kind      (kind),
    .null_flt  (null_flt),
    .rights_flt(rights_flt),
    .xdn_eff   (xdn_eff)
  );

  seg_limit_chk #(.VA_W(VA_W), .LIM_W(LIM_W), .SZ_W(SZ_W)) u_limit (
    .vaddr  (vaddr),
    .base   (seg_base),
    .limit  (seg_limit),
    .size   (acc_size),
    .wexp   (wexp),
    .xdn    (xdn_eff),
    .lim_flt(lim_flt)
  );

  seg_addr_mask #(.VA_W(VA_W)) u_mask (
    .vaddr   (vaddr),
    .prot_en (prot_en),
    .sub64   (sub64),
    .asz_ovr (asz_ovr),
    .eff_addr(eff_addr)
  );

  assign gp_fault = legacy_chk && (null_flt || rights_flt || lim_flt);

  // R1: no request, no fault
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !gp_fault);

  // R2: real mode passes the address and never faults
  a_r2_real_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    !prot_en |-> (!gp_fault && eff_addr == vaddr));

  // R10: 64-bit mode bypasses the segment checks
  a_r10_long_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_en && long_mode) |-> !gp_fault);

  // R9: upper address half cleared when truncation applies
  a_r9_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_en && (!sub64 || asz_ovr)) |-> (eff_addr[VA_W-1:32] == '0 &&
                                          eff_addr[31:0] == vaddr[31:0]));

  // R3: null selector on a non-exempt segment faults
  a_r3_null_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (legacy_chk && seg_sel == '0 && 32'(seg_idx) < SEG_HELPER_A) |-> gp_fault);

  // R4: write into a read-only ordinary segment faults
  a_r4_write_ro: assert property (@(posedge clk) disable iff (!rst_n)
    (legacy_chk && 32'(seg_idx) <= SEG_ORD_LAST && !attr_wr &&
     kind == ACC_WRITE) |-> gp_fault);
endmodule

// File: tb/sim_seg_guard.sv
module sim_seg_guard;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, prot_en, long_mode, sub64;
  logic [3:0]  seg_idx;
  logic [15:0] seg_sel;
  logic [63:0] seg_base;
  logic [31:0] seg_limit;
  logic        attr_rd, attr_wr, attr_xdn;
  logic [1:0]  acc_kind;
  logic [3:0]  acc_size;
  logic [1:0]  def_asz, alt_asz;
  logic        asz_ovr;
  logic [63:0] vaddr;
  logic        gp_fault;
  logic [63:0] eff_addr;

  int    n_run  = 0;
  int    n_fail = 0;
  int    cycles = 0;
  bit    done   = 0;
  string cur_tag = "R1 reset state";

  always #10 clk = ~clk;

  seg_guard u0 (.*);

  function automatic bit model_fault();
    bit        ord;
    int        e;
    int        w;
    logic [63:0] off;
    logic [64:0] endo;
    logic [64:0] lim;
    if (!req_valid || !prot_en || long_mode) return 1'b0;
    ord = (seg_idx <= 4'd6);
    if (seg_sel == 16'd0 && !(seg_idx inside {4'd6, 4'd7, 4'd8, 4'd9})) return 1'b1;
    if (ord) begin
      if (!attr_wr && (acc_kind == 2'd1 || acc_kind == 2'd2)) return 1'b1;
      if (!attr_rd && (acc_kind == 2'd0 || acc_kind == 2'd2)) return 1'b1;
    end
    e = asz_ovr ? int'(alt_asz) : int'(def_asz);
    w = 8 << e;
    off = vaddr - seg_base;
    if (w < 64) off = off & ((64'd1 << w) - 64'd1);
    endo = {1'b0, off} + 65'(acc_size) - 65'd1;
    lim  = 65'(seg_limit);
    if (ord && attr_xdn) return ({1'b0, off} <= lim) || (endo <= lim);
    return ({1'b0, off} > lim) || (endo > lim);
  endfunction

  function automatic logic [63:0] model_addr();
    if (prot_en && (!sub64 || asz_ovr)) return {32'd0, vaddr[31:0]};
    return vaddr;
  endfunction

  // Compare against the model on every clock (inputs change on negedges).
  always @(posedge clk) begin
    if (rst_n && !done) begin
      bit          ef;
      logic [63:0] ea;
      ef = model_fault();
      ea = model_addr();
      n_run++;
      if (gp_fault !== ef || eff_addr !== ea) begin
        n_fail++;
        $display("FAIL %s: actual fault=%0b addr=%h expected fault=%0b addr=%h",
                 cur_tag, gp_fault, eff_addr, ef, ea);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      n_fail++;
      $display("FAIL R11 watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic defaults();
    req_valid = 1; prot_en = 1; long_mode = 0; sub64 = 0;
    seg_idx = 4'd3; seg_sel = 16'h0010; seg_base = 64'h1000; seg_limit = 32'h0FFF;
    attr_rd = 1; attr_wr = 1; attr_xdn = 0; acc_kind = 2'd0; acc_size = 4'd4;
    def_asz = 2'd2; alt_asz = 2'd1; asz_ovr = 0; vaddr = 64'h1800;
  endtask

  task automatic tick(string t);
    cur_tag = t;
    @(negedge clk);
  endtask

  initial begin
    rst_n = 0;
    defaults();
    req_valid = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    tick("R1 reset state idle");
    seg_sel = 16'd0; attr_wr = 0; acc_kind = 2'd1;
    tick("R1 idle with faulting inputs");
    // R2 real mode
    defaults(); prot_en = 0; vaddr = 64'hDEAD_BEEF_0000_1234; seg_sel = 0;
    tick("R2 real mode passthrough");
    // R3 null selector
    defaults(); seg_sel = 0;
    tick("R3 null selector ordinary");
    seg_idx = 4'd6; tick("R3 helper A exempt");
    seg_idx = 4'd7; tick("R3 helper B exempt");
    seg_idx = 4'd8; tick("R3 task exempt");
    seg_idx = 4'd9; tick("R3 descriptor table exempt");
    seg_idx = 4'd10; tick("R3 other system not exempt");
    // R4 write rights
    defaults(); attr_wr = 0; acc_kind = 2'd1; tick("R4 write read-only");
    acc_kind = 2'd2; tick("R4 probe read-only");
    acc_kind = 2'd0; tick("R4 read of read-only ok");
    // R5 read rights
    defaults(); attr_rd = 0; tick("R5 read unreadable");
    acc_kind = 2'd3; tick("R5 fetch unreadable ok");
    acc_kind = 2'd2; tick("R5 probe unreadable");
    seg_idx = 4'd8; attr_wr = 0; acc_kind = 2'd1; tick("R5 system no rights");
    // R7 limit boundary
    defaults(); vaddr = 64'h1FFC; tick("R7 end at limit ok");
    vaddr = 64'h1FFD; tick("R7 end past limit");
    vaddr = 64'h2000; acc_size = 4'd1; tick("R7 offset past limit");
    // R8 expand-down
    defaults(); attr_xdn = 1; vaddr = 64'h1FFF; acc_size = 4'd2; tick("R8 xdn end at limit");
    vaddr = 64'h2000; tick("R8 xdn above limit ok");
    vaddr = 64'h1800; tick("R8 xdn below limit");
    seg_idx = 4'd7; tick("R8 xdn ignored on system");
    // R6 width selection
    defaults(); def_asz = 2'd1; seg_base = 64'h0; seg_limit = 32'h0FFF;
    vaddr = 64'h1_0010; tick("R6 16-bit offset wraps");
    asz_ovr = 1; alt_asz = 2'd2; tick("R6 override 32-bit width");
    def_asz = 2'd2; alt_asz = 2'd0; vaddr = 64'h1_0105; tick("R6 override 8-bit width");
    // R9 masking
    defaults(); vaddr = 64'hABCD_0000_0000_1800; seg_base = 64'hABCD_0000_0000_1000;
    tick("R9 truncated outside 64-bit");
    sub64 = 1; long_mode = 1; tick("R9 untouched in 64-bit");
    asz_ovr = 1; tick("R9 override truncates");
    // R10 long mode bypass
    defaults(); long_mode = 1; sub64 = 1; seg_sel = 0; attr_wr = 0; acc_kind = 2'd1;
    seg_limit = 0; tick("R10 long mode bypass");
    // R11 back-to-back changes, plus random mix
    for (int i = 0; i < 400; i++) begin
      req_valid = ($urandom_range(0, 9) != 0);
      prot_en   = ($urandom_range(0, 7) != 0);
      long_mode = ($urandom_range(0, 7) == 0);
      sub64     = 1'($urandom);
      seg_idx   = 4'($urandom);
      seg_sel   = ($urandom_range(0, 5) == 0) ? 16'd0 : 16'($urandom);
      seg_base  = {32'($urandom), 32'($urandom_range(0, 4096))};
      seg_limit = 32'($urandom_range(0, 8192));
      attr_rd   = ($urandom_range(0, 5) != 0);
      attr_wr   = ($urandom_range(0, 3) != 0);
      attr_xdn  = ($urandom_range(0, 4) == 0);
      acc_kind  = 2'($urandom);
      acc_size  = 4'($urandom_range(1, 15));
      def_asz   = 2'($urandom);
      alt_asz   = 2'($urandom);
      asz_ovr   = 1'($urandom);
      vaddr     = seg_base + 64'($urandom_range(0, 9000));
      tick("R11 random same-cycle result");
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule